// File: doc/BRIEF.md
# MDIO Clause-22 Gateway Master

This block is a management master for Ethernet PHYs. Software talks to it through a small register port. It programs the MDC timing, then writes one 32-bit gateway command word. That word names the PHY, the register, the opcode and the 16-bit data, and it carries a busy bit. While busy is set, the block serialises one Clause-22 frame on MDC and MDIO, then clears busy by itself. On a read, the 16 bits the PHY returns land in the data field of the gateway word and in a separate read-data register.

When a frame finishes, the gateway locks. It takes no new command until software writes an all-zero word to it, which makes the write/poll/release sequence of a driver explicit. The MDC half-period is programmed as a count of core cycles. The points where MDIO is driven and where it is sampled are also programmable, in core cycles, relative to the MDC edges. Configuration written mid-frame is held back until the block is idle.

Register map (word address on `wr_addr_i` and `rd_addr_i`): 0 is the gateway command word, 1 is the read data in bits [15:0], 2 is the MDC period setting P in bits [7:0], and 3 holds the sample offsets, with the input offset I in bits [7:0] and the output offset O in bits [23:16]. The half-period is H = max(P,1)+1 core cycles.

Top module: `mdio_gw_master`

## Requirements
- R1: Gateway word layout: data [15:0], register address [20:16], PHY address [25:21], opcode [27:26], start field [29:28], busy [30]. Writing a word with bit 30 set to an idle, unlocked gateway starts a frame. Bit 30 reads 1 until it clears on the clock edge 1+128·H edges after the edge that captured the write. All other fields read back as written, except the data field after a read.
- R2: Each frame is 64 bits, most significant bit first, in this order: 32 ones, the start pattern 0 then 1 (always, whatever the start field holds), the opcode, the PHY address and the register address.
- R3: With an opcode other than 2'b10, the frame continues with the turnaround bits 1 then 0 and the 16 data bits, and the MDIO output enable is high for all 64 bits.
- R4: Opcode 2'b10 is a read. The output enable is high for the first 46 bits and low for the turnaround and data bits. The 16 bits sampled in bits 48..63 (first is the MSB) are written into gateway bits [15:0] and into the read-data register when busy clears.
- R5: During a frame, MDC is low for the first H cycles of each bit and high for the next H cycles, so consecutive rising edges are 2·H cycles apart. MDC is low and the output enable is low whenever busy is 0.
- R6: MDIO output and enable change on the clock edge min(O,H−2)+1 edges after the edge on which MDC fell.
- R7: MDIO input is sampled on the clock edge min(I,H−1)+1 edges after the edge on which MDC rose.
- R8: After a frame completes, the gateway is locked. Any non-zero write to address 0 leaves the word unchanged and starts no frame. Writing zero clears the word and releases the lock.
- R9: A write to address 0 while busy is 1 is ignored and the word keeps its contents.
- R10: Writes to addresses 2 and 3 read back at once. A value written while busy is 1 does not change the running frame's timing and applies from the next frame.
- R11: After reset, the gateway and read data read 0, P=49, I=6, O=13, MDC is low, the output enable is low and MDIO output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bound checker watches four things on every cycle. MDC and the output enable must be quiet while idle. The gateway word must be stable during busy and during the lock. Completion must set the lock. The enable must match the bit position for reads and writes. The serial content of the frames depends on scenarios: the forced start pattern, the turnaround, MDC spacing, exact frame length, and the drive and sample offsets with their clamping. The bench shows these through a PHY model that presents read data only on the single edge where the master should sample it. Deferred configuration and ignored writes are shown by stimulus issued in the middle of a frame and in the locked state.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;
  localparam int GW_W       = 32;
  localparam int DATA_W     = 16;
  localparam int AD_W       = 5;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int OUT_LSB    = 16;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] ST_CL22  = 2'b01;

  typedef struct packed {
    logic              rsvd;
    logic              busy;
    logic [1:0]        st;
    logic [1:0]        op;
    logic [AD_W-1:0]   phy;
    logic [AD_W-1:0]   regad;
    logic [DATA_W-1:0] data;
  } gw_word_t;

  typedef enum logic [1:0] {
    A_GW     = 2'd0,
    A_RDATA  = 2'd1,
    A_PERIOD = 2'd2,
    A_SAMP   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_gw_regs.sv
module mdio_gw_regs
  import mdio_gw_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int OFS_W      = 8,
  parameter int DEF_PERIOD = 49,
  parameter int DEF_IN     = 6,
  parameter int DEF_OUT    = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [GW_W-1:0]     wr_data_i,
  input  logic [1:0]          rd_addr_i,
  input  logic                done_i,
  input  logic                rd_frame_i,
  input  logic [DATA_W-1:0]   cap_i,
  output logic [GW_W-1:0]     rd_data_o,
  output gw_word_t            gw_o,
  output logic                lock_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [OFS_W-1:0]    in_ofs_o,
  output logic [OFS_W-1:0]    out_ofs_o
);
  gw_word_t            gw_q;
  logic                lock_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [PERIOD_W-1:0] period_q, period_eff_q;
  logic [OFS_W-1:0]    in_q, out_q, in_eff_q, out_eff_q;
  logic                wr_gw, gw_accept;

  assign wr_gw     = wr_en_i && (wr_addr_i == A_GW);
  // locked gateway only takes the all-zero release word
  assign gw_accept = wr_gw && !gw_q.busy && (!lock_q || (wr_data_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gw_q    <= '0;
      lock_q  <= 1'b0;
      rdata_q <= '0;
    end else if (done_i) begin
      gw_q.busy <= 1'b0;
      lock_q    <= 1'b1;
      if (rd_frame_i) begin
        gw_q.data <= cap_i;
        rdata_q   <= cap_i;
      end
    end else if (gw_accept) begin
      gw_q   <= gw_word_t'(wr_data_i);
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PERIOD_W'(DEF_PERIOD);
      in_q     <= OFS_W'(DEF_IN);
      out_q    <= OFS_W'(DEF_OUT);
    end else if (wr_en_i) begin
      if (wr_addr_i == A_PERIOD) period_q <= wr_data_i[PERIOD_W-1:0];
      if (wr_addr_i == A_SAMP) begin
        in_q  <= wr_data_i[OFS_W-1:0];
        out_q <= wr_data_i[OUT_LSB +: OFS_W];
      end
    end
  end

  // timing seen by the engine only follows config while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_eff_q <= PERIOD_W'(DEF_PERIOD);
      in_eff_q     <= OFS_W'(DEF_IN);
      out_eff_q    <= OFS_W'(DEF_OUT);
    end else if (!gw_q.busy) begin
      period_eff_q <= period_q;
      in_eff_q     <= in_q;
      out_eff_q    <= out_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_GW:     rd_data_o = gw_q;
      A_RDATA:  rd_data_o[DATA_W-1:0] = rdata_q;
      A_PERIOD: rd_data_o[PERIOD_W-1:0] = period_q;
      default: begin
        rd_data_o[OFS_W-1:0]        = in_q;
        rd_data_o[OUT_LSB +: OFS_W] = out_q;
      end
    endcase
  end

  assign gw_o      = gw_q;
  assign lock_o    = lock_q;
  assign period_o  = period_eff_q;
  assign in_ofs_o  = in_eff_q;
  assign out_ofs_o = out_eff_q;
endmodule

// File: rtl/mdio_gw_clkgen.sv
module mdio_gw_clkgen #(
  parameter int PERIOD_W = 8,
  parameter int OFS_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [OFS_W-1:0]    in_ofs_i,
  input  logic [OFS_W-1:0]    out_ofs_i,
  output logic                mdc_o,
  output logic                drive_o,
  output logic                sample_o,
  output logic                bit_end_o
);
  localparam int CW = ((PERIOD_W > OFS_W) ? PERIOD_W : OFS_W) + 2;

  logic [CW-1:0] per_ext, half, full_m1, out_ext, in_ext, out_eff, in_eff;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          mdc_q;

  always_comb begin
    per_ext = CW'(period_i);
    if (per_ext == '0) per_ext = CW'(1);
    half    = per_ext + CW'(1);
    full_m1 = (half << 1) - CW'(1);
    out_ext = CW'(out_ofs_i);
    in_ext  = CW'(in_ofs_i);
    // drive settles at least one cycle before the rising edge
    out_eff = (out_ext > half - CW'(2)) ? half - CW'(2) : out_ext;
    in_eff  = (in_ext  > half - CW'(1)) ? half - CW'(1) : in_ext;
  end

  assign drive_o   = en_i && (cnt_q == out_eff);
  assign sample_o  = en_i && (cnt_q == half + in_eff);
  assign bit_end_o = en_i && (cnt_q == full_m1);

  always_comb begin
    if (!en_i || bit_end_o) cnt_nxt = '0;
    else                    cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      mdc_q <= en_i && !bit_end_o && (cnt_nxt >= half);
    end
  end

  assign mdc_o = mdc_q;
endmodule

// File: rtl/mdio_gw_frame.sv
module mdio_gw_frame
  import mdio_gw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  gw_word_t          cmd_i,
  input  logic              drive_i,
  input  logic              sample_i,
  input  logic              bit_end_i,
  input  logic              mdio_i,
  output logic              running_o,
  output logic              done_o,
  output logic              is_read_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic                  run_q, rd_q, mdo_q, oe_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] sr_q, frame_load;
  logic [DATA_W-1:0]     cap_q;
  logic                  cmd_rd;
  logic [1:0]            ta;

  assign cmd_rd     = (cmd_i.op == OP_READ);
  assign ta         = cmd_rd ? 2'b11 : 2'b10;
  assign frame_load = {{PRE_BITS{1'b1}}, ST_CL22, cmd_i.op, cmd_i.phy, cmd_i.regad, ta, cmd_i.data};

  assign done_o = run_q && bit_end_i && (bit_q == BIT_W'(FRAME_BITS - 1));
  assign cap_o  = (sample_i && rd_q && (bit_q >= BIT_W'(DATA_FIRST)))
                  ? {cap_q[DATA_W-2:0], mdio_i} : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      rd_q  <= 1'b0;
      bit_q <= '0;
      sr_q  <= '0;
      cap_q <= '0;
      mdo_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      rd_q  <= cmd_rd;
      bit_q <= '0;
      sr_q  <= frame_load;
      cap_q <= '0;
    end else if (run_q) begin
      cap_q <= cap_o;
      if (drive_i) begin
        mdo_q <= sr_q[FRAME_BITS-1];
        sr_q  <= sr_q << 1;
        oe_q  <= !rd_q || (bit_q < BIT_W'(TA_FIRST));
      end
      if (bit_end_i) begin
        if (done_o) begin
          run_q <= 1'b0;
          oe_q  <= 1'b0;
          mdo_q <= 1'b1;
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
      end
    end
  end

  assign running_o = run_q;
  assign is_read_o = rd_q;
  assign bit_idx_o = bit_q;
  assign mdio_o    = mdo_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
  import mdio_gw_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int OFS_W      = 8,
  parameter int DEF_PERIOD = 49,
  parameter int DEF_IN     = 6,
  parameter int DEF_OUT    = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  gw_word_t            gw;
  logic                lock, running, frame_done, is_read, start;
  logic                drive, sample, bit_end;
  logic [BIT_W-1:0]    bit_idx;
  logic [DATA_W-1:0]   cap;
  logic [PERIOD_W-1:0] period;
  logic [OFS_W-1:0]    in_ofs, out_ofs;

  assign start = gw.busy && !running;

  mdio_gw_regs #(
    .PERIOD_W(PERIOD_W), .OFS_W(OFS_W),
    .DEF_PERIOD(DEF_PERIOD), .DEF_IN(DEF_IN), .DEF_OUT(DEF_OUT)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .done_i(frame_done), .rd_frame_i(is_read), .cap_i(cap),
    .rd_data_o, .gw_o(gw), .lock_o(lock),
    .period_o(period), .in_ofs_o(in_ofs), .out_ofs_o(out_ofs)
  );

  mdio_gw_clkgen #(.PERIOD_W(PERIOD_W), .OFS_W(OFS_W)) i_clkgen (
    .clk_i, .rst_ni, .en_i(running),
    .period_i(period), .in_ofs_i(in_ofs), .out_ofs_i(out_ofs),
    .mdc_o, .drive_o(drive), .sample_o(sample), .bit_end_o(bit_end)
  );

  mdio_gw_frame i_frame (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(gw),
    .drive_i(drive), .sample_i(sample), .bit_end_i(bit_end), .mdio_i,
    .running_o(running), .done_o(frame_done), .is_read_o(is_read),
    .bit_idx_o(bit_idx), .cap_o(cap), .mdio_o, .mdio_oe_o
  );
endmodule

// File: rtl/mdio_gw_checker.sv
module mdio_gw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        mdc_o,
  input logic        mdio_oe_o,
  input logic [31:0] gw_word,
  input logic        gw_busy,
  input logic        lock,
  input logic        running,
  input logic        frame_done,
  input logic        is_read,
  input logic [5:0]  bit_idx
);
  logic zero_gw_wr;
  assign zero_gw_wr = wr_en_i && (wr_addr_i == 2'd0) && (wr_data_i == 32'd0);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_busy |-> (!mdc_o && !mdio_oe_o));

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_busy && !frame_done) |=> $stable(gw_word));

  p_lock_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> (lock && !gw_busy));

  p_lock_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !gw_busy && !zero_gw_wr) |=> (!gw_busy && $stable(gw_word)));

  p_read_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && is_read && (bit_idx >= 6'd47)) |-> !mdio_oe_o);

  p_write_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !is_read && (bit_idx >= 6'd1)) |-> mdio_oe_o);
endmodule

bind mdio_gw_master mdio_gw_checker i_mdio_gw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .mdc_o(mdc_o), .mdio_oe_o(mdio_oe_o),
  .gw_word(gw), .gw_busy(gw.busy), .lock(lock), .running(running),
  .frame_done(frame_done), .is_read(is_read), .bit_idx(bit_idx)
);

// File: tb/test_mdio_gw_master.sv
`timescale 1ns/1ps
module test_mdio_gw_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mdc, mdo, mdoe;
  logic        mdi = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  int cfg_p = 49, cfg_in = 6, cfg_out = 13;

  logic [63:0] obs_o, obs_oe;
  int          rise_cyc [64];
  int          dur, off_delta;
  bit          got_delta, txn_done;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_gw_master i_mdio_gw_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int half_of(int p);
    return ((p < 1) ? 1 : p) + 1;
  endfunction
  function automatic int in_of(int i, int h);
    return (i > h - 1) ? h - 1 : i;
  endfunction
  function automatic int out_of(int o, int h);
    return (o > h - 2) ? h - 2 : o;
  endfunction
  function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] phy,
                                            logic [4:0] ra, logic [15:0] d);
    logic [1:0] ta = (op == 2'b10) ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, d};
  endfunction
  function automatic logic [31:0] mk_word(logic [1:0] st, logic [1:0] op, logic [4:0] phy,
                                          logic [4:0] ra, logic [15:0] d);
    return {1'b0, 1'b1, st, op, phy, ra, d};
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
    rd_addr = 2'd0;
    #0;
  endtask

  task automatic phy_serve(bit is_rd, logic [15:0] d, int ine);
    for (int n = 0; n < 64; n++) begin
      logic v;
      @(posedge mdc);
      #1;
      obs_o[63-n]  = mdo;
      obs_oe[63-n] = mdoe;
      rise_cyc[n]  = cyc;
      if (is_rd && n >= 48) begin
        v = d[63-n];
        mdi = ~v;
        repeat (ine) @(posedge clk);
        #1 mdi = v;
        @(posedge clk);
        #1 mdi = ~v;
      end else begin
        mdi = 1'b1;
      end
    end
    mdi = 1'b1;
  endtask

  task automatic wait_done(int limit);
    dur = 0;
    while (rd_data[30] === 1'b1 && dur <= limit) begin
      @(negedge clk);
      dur++;
    end
    txn_done = 1;
  endtask

  task automatic watch_offset();
    logic mdc_p = mdc, mdo_p = mdo;
    int fall_c = 0;
    while (!got_delta && !txn_done) begin
      @(negedge clk);
      if (mdc_p && !mdc) fall_c = cyc;
      if (mdo_p && !mdo && mdoe) begin
        off_delta = cyc - fall_c;
        got_delta = 1;
      end
      mdc_p = mdc;
      mdo_p = mdo;
    end
  endtask

  // inject: ignored gateway write and a period change during busy
  task automatic run_txn(logic [1:0] st, logic [1:0] op, logic [4:0] phy, logic [4:0] ra,
                         logic [15:0] d, bit inject, int new_p);
    int h = half_of(cfg_p);
    int ine = in_of(cfg_in, h);
    int oute = out_of(cfg_out, h);
    bit is_rd = (op == 2'b10);
    logic [31:0] w = mk_word(st, op, phy, ra, d);
    logic [15:0] phy_d = d ^ 16'h5A3C;
    logic [63:0] ef = exp_frame(op, phy, ra, d);
    logic [63:0] mask = is_rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    logic [31:0] rv, exp_w;
    bit spacing_ok = 1;
    got_delta = 0; txn_done = 0; off_delta = -1;
    rd_addr = 2'd0;
    reg_write(2'd0, w);
    fork
      phy_serve(is_rd, phy_d, ine);
      wait_done(1 + 128 * 257);
      watch_offset();
      if (inject) begin
        repeat (40) @(negedge clk);
        reg_write(2'd0, mk_word(2'b01, 2'b01, ~phy, ~ra, ~d));
        chk("R9 gateway write during busy ignored", rd_data, w);
        reg_write(2'd2, 32'(new_p));
        reg_read(2'd2, rv);
        chk("R10 period readback during busy", rv, 64'(new_p));
      end
    join
    chk("R1 busy clear edge count", 64'(dur), 64'(1 + 128 * h));
    chk(is_rd ? "R2 read frame header" : "R2 R3 write frame bits", obs_o & mask, ef & mask);
    chk(is_rd ? "R4 read output enable" : "R3 write output enable", obs_oe, mask);
    for (int n = 1; n < 64; n++)
      if (rise_cyc[n] - rise_cyc[n-1] != 2 * h) spacing_ok = 0;
    chk("R5 MDC rising edge spacing", 64'(spacing_ok), 64'd1);
    chk("R6 drive offset after MDC fall", 64'(off_delta), 64'(oute + 1));
    exp_w = w;
    exp_w[30] = 1'b0;
    if (is_rd) exp_w[15:0] = phy_d;
    chk("R1 R4 gateway word after completion", rd_data, exp_w);
    if (is_rd) begin
      reg_read(2'd1, rv);
      chk("R4 R7 read data register", rv, {16'h0, phy_d});
    end
    if (inject) cfg_p = new_p;
  endtask

  task automatic release_gw();
    reg_write(2'd0, 32'd0);
    chk("R8 zero write releases gateway", rd_data, 64'd0);
  endtask

  task automatic set_cfg(int p, int i, int o);
    logic [31:0] rv;
    reg_write(2'd2, 32'(p));
    reg_write(2'd3, (32'(o) << 16) | 32'(i));
    cfg_p = p; cfg_in = i; cfg_out = o;
    reg_read(2'd3, rv);
    chk("R10 offset register readback", rv, (64'(o) << 16) | 64'(i));
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, w2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    reg_read(2'd0, rv); chk("R11 gateway after reset", rv, 64'd0);
    reg_read(2'd1, rv); chk("R11 read data after reset", rv, 64'd0);
    reg_read(2'd2, rv); chk("R11 period after reset", rv, 64'd49);
    reg_read(2'd3, rv); chk("R11 offsets after reset", rv, 64'h000D_0006);
    chk("R11 pins after reset", {61'd0, mdc, mdoe, mdo}, 64'b001);

    // default timing, write with start field 00 still sends 01
    run_txn(2'b00, 2'b01, 5'h15, 5'h0A, 16'hC3A5, 0, 0);

    // lock: non-zero write ignored, no MDC activity
    rd_addr = 2'd0;
    #1 w2 = rd_data;
    reg_write(2'd0, mk_word(2'b01, 2'b10, 5'h01, 5'h02, 16'h1234));
    begin
      bit quiet = 1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (mdc !== 1'b0 || rd_data !== w2) quiet = 0;
      end
      chk("R8 locked gateway ignores command", 64'(quiet), 64'd1);
    end
    release_gw();

    // fast timing, read
    set_cfg(3, 1, 0);
    run_txn(2'b01, 2'b10, 5'h1F, 5'h00, 16'h8001, 0, 0);
    release_gw();

    // clamping: P=0 -> H=2, offsets beyond phase
    set_cfg(0, 9, 9);
    run_txn(2'b01, 2'b10, 5'h00, 5'h1F, 16'h7E81, 0, 0);
    release_gw();
    run_txn(2'b01, 2'b01, 5'h0C, 5'h11, 16'h0FF0, 0, 0);
    release_gw();

    // input offset at end of high phase
    set_cfg(5, 5, 4);
    run_txn(2'b01, 2'b10, 5'h03, 5'h04, 16'hBEEF, 0, 0);
    release_gw();

    // busy-time writes: ignored command, deferred period
    set_cfg(4, 2, 1);
    run_txn(2'b01, 2'b10, 5'h09, 5'h06, 16'h4D2B, 1, 2);
    release_gw();
    run_txn(2'b01, 2'b01, 5'h12, 5'h07, 16'hA5A5, 0, 0);
    release_gw();

    // constrained random
    for (int t = 0; t < 14; t++) begin
      int p = 1 + ($urandom % 7);
      int i = $urandom % 12;
      int o = $urandom % 12;
      logic [1:0] op = ($urandom % 2) ? 2'b10 : 2'b01;
      set_cfg(p, i, o);
      run_txn(2'b01, op, 5'($urandom), 5'($urandom), 16'($urandom), 0, 0);
      release_gw();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule